// File: doc/BRIEF.md
# Transport Header Sanity Checker

This block examines the transport-layer header of a received IPv4 packet whose TCP or UDP segment arrives one byte per cycle, with first-byte and last-byte markers. Side inputs carry what an upstream IP parser has already found: whether the segment is TCP or UDP, the IP payload length, the source and destination addresses, whether the packet is a fragment, and whether an earlier stage has already flagged the packet. The bytes are summed on the fly. When the last byte is taken, the block returns a one-bit error flag and an 8-bit error code. The code reports a malformed header, a bad checksum, a bad UDP length, a zero port, or one of six suspicious TCP flag combinations.

The result is presented with a valid/ready handshake. While a result waits to be taken, the byte input is closed (`inReady` low). The side inputs must be held from the first byte until that handshake completes.

Top module: `l4_check_top`

## Requirements
- R1: After reset, `resValid` is 0 and `inReady` is 1.
- R2: A segment with fewer bytes than the minimum header gives code 1. The minimum is 8 bytes for UDP and 20 bytes for TCP.
- R3: The block forms a 16-bit ones-complement sum over the segment bytes and a pseudo-header. Bytes at even offsets are the high half of a word, and an odd last byte is padded with zero. The pseudo-header is both 32-bit addresses, the protocol number (6 for TCP, 17 for UDP) and `ipLen`. Code 2 results unless the sum is 0xFFFF. Exception: a UDP checksum field of zero disables the check. The checksum field is at bytes 6-7 for UDP and bytes 16-17 for TCP.
- R4: For UDP, a length field (bytes 4-5, big-endian) larger than `ipLen` gives code 3.
- R5: A zero source port (bytes 0-1) or a zero destination port (bytes 2-3) gives code 4, for either protocol.
- R6: For TCP, the flags byte is byte 13, with FIN at bit 0, SYN at bit 1, RST at bit 2, PSH at bit 3, ACK at bit 4 and URG at bit 5. The codes are:
  - FIN alone (bits 5:0 equal to 000001): code 8.
  - Bits 5:0 all clear: code 9.
  - FIN and RST: code 10.
  - SYN and URG: code 11.
  - SYN and RST: code 12.
  - SYN and FIN: code 13.
  - UDP never yields codes 8 to 13.
- R7: When several conditions hold, the lowest code wins. With no condition, code is 0 and `errFlag` is 0. Otherwise `errFlag` is 1.
- R8: When `isFrag` or `priorErr` is 1, the result is code 0 with `errFlag` 0.
- R9: `resValid` rises in the cycle after the last byte is accepted. While `resValid` is 1, `inReady` is 0, and code and flag stay stable until `resReady` is seen. The cycle after that, `resValid` is 0.
- R10: Bytes offered while idle without `inSof` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Byte present |
| inSof | input | 1 | Byte is the first of the segment |
| inEof | input | 1 | Byte is the last of the segment |
| inByte | input | 8 | Segment byte |
| inReady | output | 1 | Block accepts bytes |
| protoTcp | input | 1 | 1 for TCP, 0 for UDP |
| ipLen | input | 16 | IP payload (segment) length in bytes |
| srcAddr | input | 32 | IPv4 source address |
| dstAddr | input | 32 | IPv4 destination address |
| isFrag | input | 1 | Packet is a fragment |
| priorErr | input | 1 | An earlier stage already flagged the packet |
| resValid | output | 1 | Result available |
| resReady | input | 1 | Result taken |
| errFlag | output | 1 | Any error found |
| errCode | output | 8 | Error code |

## Verification
Most wrong internal states surface on `errCode` in the cycle after the final byte. Examples are a byte counter that skipped or repeated a byte, a header field latched from the wrong offset, or a sum started from a stale value from the previous segment. Such faults show up as a wrong code, or as a missing code 0, for a segment built to hit exactly one condition. Segments that hit several conditions at once expose a misordered priority chain in that same cycle. A control state stuck in its holding phase shows up as `inReady` staying low, or as `resValid` not dropping, one cycle after `resReady`.

// File: rtl/l4_check_pkg.sv
package l4_check_pkg;
  localparam int LEN_W   = 16;
  localparam int SUM_W   = 32;
  localparam int UDP_MIN = 8;
  localparam int TCP_MIN = 20;

  localparam logic [7:0] C_OK      = 8'd0;
  localparam logic [7:0] C_SHORT   = 8'd1;
  localparam logic [7:0] C_CSUM    = 8'd2;
  localparam logic [7:0] C_ULEN    = 8'd3;
  localparam logic [7:0] C_PORT    = 8'd4;
  localparam logic [7:0] C_FINONLY = 8'd8;
  localparam logic [7:0] C_NOFLAG  = 8'd9;
  localparam logic [7:0] C_FINRST  = 8'd10;
  localparam logic [7:0] C_SYNURG  = 8'd11;
  localparam logic [7:0] C_SYNRST  = 8'd12;
  localparam logic [7:0] C_SYNFIN  = 8'd13;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_HOLD} ctlState_t;

  typedef struct packed {
    logic take;    // byte enters the datapath
    logic first;   // byte is at offset zero
    logic finish;  // byte is the last, latch the result
  } ctlStrobe_t;
endpackage

// File: rtl/l4_check_ctrl.sv
module l4_check_ctrl
  import l4_check_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       inSof,
  input  logic       inEof,
  input  logic       resReady,
  output logic       inReady,
  output logic       resValid,
  output ctlStrobe_t strobe
);
  ctlState_t state, stateNext;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    case (state)
      ST_IDLE: begin
        strobe.take   = inValid && inSof;
        strobe.first  = inValid && inSof;
        strobe.finish = inValid && inSof && inEof;
        if (inValid && inSof) stateNext = inEof ? ST_HOLD : ST_RUN;
      end
      ST_RUN: begin
        strobe.take   = inValid;
        strobe.finish = inValid && inEof;
        if (inValid && inEof) stateNext = ST_HOLD;
      end
      default: begin
        if (resReady) stateNext = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign inReady  = (state != ST_HOLD);
  assign resValid = (state == ST_HOLD);

  // R9: a taken result is withdrawn on the following cycle
  p_release_r9: assert property (@(posedge clk) disable iff (!rstN)
    resValid && resReady |=> !resValid);

  // R9: the last byte leads to a pending result
  p_finish_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.finish |=> resValid && !inReady);
endmodule

// File: rtl/l4_check_dp.sv
module l4_check_dp
  import l4_check_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  input  logic [7:0]       inByte,
  input  logic             protoTcp,
  input  logic [LEN_W-1:0] ipLen,
  input  logic [31:0]      srcAddr,
  input  logic [31:0]      dstAddr,
  input  logic             suppress,
  output logic [7:0]       errCode
);
  localparam logic [LEN_W-1:0] OFS_UDP_CS = LEN_W'(6);
  localparam logic [LEN_W-1:0] OFS_TCP_CS = LEN_W'(16);
  localparam logic [LEN_W-1:0] OFS_FLAGS  = LEN_W'(13);

  logic [LEN_W-1:0] cnt, cntNext, idx, csOfs;
  logic [SUM_W-1:0] sum, sumNext, pseudo, total;
  logic [15:0]      srcPort, dstPort, udpLen, csField;
  logic [15:0]      srcPortN, dstPortN, udpLenN, csFieldN;
  logic [5:0]       flags, flagsN;
  logic [16:0]      fold1, fold2;
  logic             shortSeg, csumBad, lenBad, portBad;
  logic             fin, syn, rst, urg;
  logic [7:0]       codeNow;

  assign idx   = strobe.first ? '0 : cnt;
  assign csOfs = protoTcp ? OFS_TCP_CS : OFS_UDP_CS;

  always_comb begin
    cntNext  = cnt;
    sumNext  = sum;
    srcPortN = srcPort;
    dstPortN = dstPort;
    udpLenN  = udpLen;
    csFieldN = csField;
    flagsN   = flags;
    if (strobe.take) begin
      if (strobe.first) begin
        sumNext  = '0;
        srcPortN = '0;
        dstPortN = '0;
        udpLenN  = '0;
        csFieldN = '0;
        flagsN   = '0;
      end
      cntNext = idx + 1'b1;
      sumNext = sumNext + (idx[0] ? SUM_W'(inByte) : SUM_W'({inByte, 8'h00}));
      if (idx == LEN_W'(0)) srcPortN[15:8] = inByte;
      if (idx == LEN_W'(1)) srcPortN[7:0]  = inByte;
      if (idx == LEN_W'(2)) dstPortN[15:8] = inByte;
      if (idx == LEN_W'(3)) dstPortN[7:0]  = inByte;
      if (idx == LEN_W'(4)) udpLenN[15:8]  = inByte;
      if (idx == LEN_W'(5)) udpLenN[7:0]   = inByte;
      if (idx == csOfs)          csFieldN[15:8] = inByte;
      if (idx == csOfs + 1'b1)   csFieldN[7:0]  = inByte;
      if (idx == OFS_FLAGS)      flagsN         = inByte[5:0];
    end
  end

  // final checks on the post-byte values
  always_comb begin
    pseudo = SUM_W'(srcAddr[31:16]) + SUM_W'(srcAddr[15:0])
           + SUM_W'(dstAddr[31:16]) + SUM_W'(dstAddr[15:0])
           + SUM_W'(protoTcp ? 8'd6 : 8'd17) + SUM_W'(ipLen);
    total  = sumNext + pseudo;
    fold1  = {1'b0, total[15:0]} + {1'b0, total[31:16]};
    fold2  = {1'b0, fold1[15:0]} + 17'(fold1[16]);
    shortSeg = cntNext < (protoTcp ? LEN_W'(TCP_MIN) : LEN_W'(UDP_MIN));
    csumBad  = (fold2[15:0] != 16'hFFFF) && !(!protoTcp && csFieldN == 16'h0000);
    lenBad   = !protoTcp && (udpLenN > ipLen);
    portBad  = (srcPortN == 16'h0000) || (dstPortN == 16'h0000);
    fin = flagsN[0];
    syn = flagsN[1];
    rst = flagsN[2];
    urg = flagsN[5];
    if      (shortSeg)                         codeNow = C_SHORT;
    else if (csumBad)                          codeNow = C_CSUM;
    else if (lenBad)                           codeNow = C_ULEN;
    else if (portBad)                          codeNow = C_PORT;
    else if (protoTcp && flagsN == 6'b000001)  codeNow = C_FINONLY;
    else if (protoTcp && flagsN == 6'b000000)  codeNow = C_NOFLAG;
    else if (protoTcp && fin && rst)           codeNow = C_FINRST;
    else if (protoTcp && syn && urg)           codeNow = C_SYNURG;
    else if (protoTcp && syn && rst)           codeNow = C_SYNRST;
    else if (protoTcp && syn && fin)           codeNow = C_SYNFIN;
    else                                       codeNow = C_OK;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      sum     <= '0;
      srcPort <= '0;
      dstPort <= '0;
      udpLen  <= '0;
      csField <= '0;
      flags   <= '0;
      errCode <= C_OK;
    end else begin
      cnt     <= cntNext;
      sum     <= sumNext;
      srcPort <= srcPortN;
      dstPort <= dstPortN;
      udpLen  <= udpLenN;
      csField <= csFieldN;
      flags   <= flagsN;
      if (strobe.finish) errCode <= suppress ? C_OK : codeNow;
    end
  end

  // R9: the code changes only when a segment ends
  p_code_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> $stable(errCode));

  // R6: only defined codes ever appear
  p_code_legal_r6: assert property (@(posedge clk) disable iff (!rstN)
    errCode inside {8'd0, 8'd1, 8'd2, 8'd3, 8'd4, 8'd8, 8'd9, 8'd10, 8'd11, 8'd12, 8'd13});
endmodule

// File: rtl/l4_check_top.sv
module l4_check_top
  import l4_check_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        inSof,
  input  logic        inEof,
  input  logic [7:0]  inByte,
  output logic        inReady,
  input  logic        protoTcp,
  input  logic [15:0] ipLen,
  input  logic [31:0] srcAddr,
  input  logic [31:0] dstAddr,
  input  logic        isFrag,
  input  logic        priorErr,
  output logic        resValid,
  input  logic        resReady,
  output logic        errFlag,
  output logic [7:0]  errCode
);
  ctlStrobe_t strobe;

  l4_check_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .resReady(resReady), .inReady(inReady), .resValid(resValid), .strobe(strobe)
  );

  l4_check_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inByte(inByte), .protoTcp(protoTcp),
    .ipLen(ipLen), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .suppress(isFrag || priorErr), .errCode(errCode)
  );

  assign errFlag = (errCode != 8'd0);

  // R9: the last accepted byte yields a result next cycle
  p_eof_result_r9: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && inEof && (inSof || !$past(inReady) || 1'b1) && u_ctrl.state == ST_RUN
      |=> resValid);

  // R9: a pending result holds still until taken
  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !resReady |=> resValid && $stable(errCode));

  // R8: suppressed packets report nothing
  p_suppress_r8: assert property (@(posedge clk) disable iff (!rstN)
    resValid && (isFrag || priorErr) |-> !errFlag);

  // R6: UDP never yields a TCP flag code
  p_udp_codes_r6: assert property (@(posedge clk) disable iff (!rstN)
    resValid && !protoTcp |-> errCode <= 8'd4);
endmodule

// File: tb/sim_l4_check_top.sv
`timescale 1ns/1ps
module sim_l4_check_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inSof = 1'b0, inEof = 1'b0;
  logic [7:0]  inByte = 8'h00;
  logic        inReady;
  logic        protoTcp = 1'b0;
  logic [15:0] ipLen = 16'd0;
  logic [31:0] srcAddr = 32'hC0A8_0A01, dstAddr = 32'h0A00_00FE;
  logic        isFrag = 1'b0, priorErr = 1'b0;
  logic        resValid, resReady = 1'b0, errFlag;
  logic [7:0]  errCode;

  int nChecks = 0, nFail = 0;
  logic [7:0] pkt [0:63];

  always #2.5 clk = ~clk;

  l4_check_top u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSof(inSof), .inEof(inEof),
    .inByte(inByte), .inReady(inReady), .protoTcp(protoTcp), .ipLen(ipLen),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .isFrag(isFrag), .priorErr(priorErr),
    .resValid(resValid), .resReady(resReady), .errFlag(errFlag), .errCode(errCode)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic mkUdp(input int n, input int sp, input int dp, input int ulen);
    for (int i = 0; i < 64; i++) pkt[i] = 8'((i * 7 + 3) & 255);
    pkt[0] = 8'(sp >> 8); pkt[1] = 8'(sp);
    pkt[2] = 8'(dp >> 8); pkt[3] = 8'(dp);
    pkt[4] = 8'(ulen >> 8); pkt[5] = 8'(ulen);
    if (n < 0) pkt[0] = 8'h00;
  endtask

  task automatic mkTcp(input int sp, input int dp, input int flg);
    for (int i = 0; i < 64; i++) pkt[i] = 8'((i * 13 + 5) & 255);
    pkt[0] = 8'(sp >> 8); pkt[1] = 8'(sp);
    pkt[2] = 8'(dp >> 8); pkt[3] = 8'(dp);
    pkt[12] = 8'h50;
    pkt[13] = 8'(flg);
  endtask

  // ones-complement checksum written into the segment, per R3
  task automatic fixCsum(input bit tcp, input int n, input int len);
    int s, pos, c;
    pos = tcp ? 16 : 6;
    pkt[pos] = 8'h00; pkt[pos + 1] = 8'h00;
    s = int'(srcAddr[31:16]) + int'(srcAddr[15:0]) + int'(dstAddr[31:16])
      + int'(dstAddr[15:0]) + (tcp ? 6 : 17) + len;
    for (int i = 0; i < n; i++) s += (i % 2 == 1) ? int'(pkt[i]) : (int'(pkt[i]) << 8);
    while ((s >> 16) != 0) s = (s & 16'hFFFF) + (s >> 16);
    c = (~s) & 16'hFFFF;
    if (!tcp && c == 0) c = 16'hFFFF;
    pkt[pos] = 8'(c >> 8); pkt[pos + 1] = 8'(c);
  endtask

  task automatic sendPkt(input string tag, input int n, input bit tcp, input int len,
                         input bit frag, input bit prior, input int expCode, input int holdCyc);
    protoTcp = tcp; ipLen = 16'(len); isFrag = frag; priorErr = prior;
    for (int i = 0; i < n; i++) begin
      inValid = 1'b1; inSof = (i == 0); inEof = (i == n - 1); inByte = pkt[i];
      @(posedge clk); #1;
    end
    inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
    check({tag, " R9 resValid"}, int'(resValid), 1);
    check({tag, " code"}, int'(errCode), expCode);
    check({tag, " R7 flag"}, int'(errFlag), int'(expCode != 0));
    for (int k = 0; k < holdCyc; k++) begin
      inValid = 1'b1; inSof = 1'b1; inEof = 1'b1; inByte = 8'h00;
      @(posedge clk); #1;
      inValid = 1'b0; inSof = 1'b0; inEof = 1'b0;
      check({tag, " R9 held valid"}, int'(resValid), 1);
      check({tag, " R9 inReady low"}, int'(inReady), 0);
      check({tag, " R9 code stable"}, int'(errCode), expCode);
    end
    resReady = 1'b1;
    @(posedge clk); #1;
    resReady = 1'b0;
    check({tag, " R9 released"}, int'(resValid), 0);
  endtask

  task automatic testReset;
    check("R1 resValid", int'(resValid), 0);
    check("R1 inReady", int'(inReady), 1);
  endtask

  task automatic testUdp;
    mkUdp(13, 1234, 53, 13); fixCsum(0, 13, 13);
    sendPkt("R3 udp odd good", 13, 0, 13, 0, 0, 0, 0);
    mkUdp(13, 1234, 53, 13); fixCsum(0, 13, 13); pkt[10] = pkt[10] ^ 8'h40;
    sendPkt("R3 udp bad sum", 13, 0, 13, 0, 0, 2, 0);
    mkUdp(12, 1234, 53, 12); pkt[6] = 8'h00; pkt[7] = 8'h00; pkt[9] = 8'hEE;
    sendPkt("R3 udp zero sum skip", 12, 0, 12, 0, 0, 0, 0);
    mkUdp(12, 1234, 53, 20); fixCsum(0, 12, 12);
    sendPkt("R4 udp len", 12, 0, 12, 0, 0, 3, 0);
    mkUdp(12, 1234, 53, 12); fixCsum(0, 12, 12);
    sendPkt("R4 udp len equal", 12, 0, 12, 0, 0, 0, 0);
    mkUdp(12, 1234, 0, 12); fixCsum(0, 12, 12);
    sendPkt("R5 udp dst port 0", 12, 0, 12, 0, 0, 4, 0);
    mkUdp(6, 1234, 53, 6);
    sendPkt("R2 udp short", 6, 0, 6, 0, 0, 1, 0);
    mkUdp(12, 1234, 53, 30);
    sendPkt("R7 sum before len", 12, 0, 12, 0, 0, 2, 0);
  endtask

  task automatic testTcp;
    int flg [8] = '{8'h01, 8'h00, 8'h05, 8'h22, 8'h06, 8'h03, 8'h10, 8'h07};
    int exp [8] = '{8, 9, 10, 11, 12, 13, 0, 10};
    for (int i = 0; i < 8; i++) begin
      mkTcp(40000, 80, flg[i]); fixCsum(1, 20, 20);
      sendPkt($sformatf("R6 tcp flags %02h", flg[i]), 20, 1, 20, 0, 0, exp[i], 0);
    end
    mkTcp(0, 80, 8'h01); fixCsum(1, 21, 21);
    sendPkt("R7 port before flags R5", 21, 1, 21, 0, 0, 4, 0);
    mkTcp(40000, 80, 8'h10); fixCsum(1, 19, 19);
    sendPkt("R2 tcp short", 19, 1, 19, 0, 0, 1, 0);
  endtask

  task automatic testSuppress;
    mkUdp(12, 1234, 53, 12); fixCsum(0, 12, 12); pkt[11] = pkt[11] ^ 8'h01;
    sendPkt("R8 fragment", 12, 0, 12, 1, 0, 0, 0);
    mkTcp(0, 80, 8'h00);
    sendPkt("R8 prior error", 20, 1, 20, 0, 1, 0, 0);
  endtask

  task automatic testIdleJunk;
    protoTcp = 1'b0;
    for (int i = 0; i < 3; i++) begin
      inValid = 1'b1; inSof = 1'b0; inEof = (i == 2); inByte = 8'h00;
      @(posedge clk); #1;
    end
    inValid = 1'b0; inEof = 1'b0;
    check("R10 no result from junk", int'(resValid), 0);
    mkUdp(10, 7, 9, 10); fixCsum(0, 10, 10);
    sendPkt("R10 after junk", 10, 0, 10, 0, 0, 0, 0);
  endtask

  task automatic testHold;
    mkTcp(40000, 80, 8'h03); fixCsum(1, 24, 24);
    sendPkt("R9 hold", 24, 1, 24, 0, 0, 13, 3);
    mkUdp(8, 1, 2, 8); fixCsum(0, 8, 8);
    sendPkt("R9 after hold", 8, 0, 8, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(posedge clk); #1;
    testReset();
    testUdp();
    testTcp();
    testSuppress();
    testIdleJunk();
    testHold();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    #200000;
    nChecks++; nFail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule